// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

A single-port synchronous memory whose write data trails its command on the shared data bus. Read and write commands may be issued on any mix of consecutive cycles, and the bus never needs an idle slot between them. Address, command, chip selects and byte enables are captured on the rising edge of `clk`. Write data is captured on a later edge, chosen so that it takes the bus slot that a read issued in the same cycle would have used.

`pipe_mode` is a static input that selects one of two read styles. With `pipe_mode`=1 (registered output), reads pass through an output register. With `pipe_mode`=0 (flow-through), read data comes straight from the array. The write-data delay follows the same choice.

Commands may start a four-beat burst. Its order is linear or interleaved, chosen by the static input `burst_ilv`. `oe_n` and `sleep` act without a clock and switch the data drivers off. `sleep` also blocks new commands.

Top module: `lw_sram`

## Requirements
- R1: A start cycle is taken only when `adv`=0, `cs0_n`=0, `cs1`=1 and `cs2_n`=0, all sampled on the rising edge. A start cycle with `we_n`=0 is a write; otherwise it is a read. A cycle with `adv`=0 and any select inactive is a deselect and ends any burst.
- R2: In flow-through mode (`pipe_mode`=0), a read captured at edge T drives `dq_drv`=1 and its data on `dq_out` from edge T until edge T+1.
- R3: In registered mode (`pipe_mode`=1), a read captured at edge T drives its data from edge T+1 until edge T+2.
- R4: Write data for a write captured at edge T is sampled from `wdata` at edge T+1 in flow-through mode, or at edge T+2 in registered mode.
- R5: Byte lane i covers bits [9i+8:9i]. It is written only when `bw_n[i]`=0 was sampled with the command.
- R6: Reads and writes may follow each other on every cycle in any mix. A read returns the newest data, including bytes of an earlier write whose data arrives on the same edge the read result is formed.
- R7: With `adv`=1 during an active burst, the previous operation type continues with burst count k = 1, 2, 3, 0, and so on. In linear order (`burst_ilv`=0) the low two address bits are (base + k) mod 4. The upper address bits are kept.
- R8: In interleaved order (`burst_ilv`=1), the low two address bits are base XOR k.
- R9: `oe_n`=1 forces `dq_drv`=0 and `dq_out`=0 at once, without disturbing commands in flight.
- R10: While `sleep`=1, `dq_drv`=0, commands and burst advances are ignored, and any burst ends. Stored contents are kept.
- R11: During and after reset, `dq_drv`=0, no operation is pending, and every word reads as zero.
- R12: `adv`=1 while no burst is active issues no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static: 1 = registered reads, 0 = flow-through |
| burst_ilv | input | 1 | Static: 1 = interleaved burst, 0 = linear |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance current burst, 0 = new command or deselect |
| we_n | input | 1 | 0 = write command, 1 = read command |
| addr | input | ADDR_W | Word address |
| bw_n | input | NBYTES | Per-byte write enables, active low |
| wdata | input | NBYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power request |
| dq_out | output | NBYTES*BYTE_W | Read data, zero when not driven |
| dq_drv | output | 1 | Data bus drive enable |

## Verification
A read's result is due in the cycle that starts at its command edge in flow-through mode, and one edge later in registered mode. A write's data is sampled one edge after its command in flow-through mode and two edges after it in registered mode. The reference model keeps every operation in a queue stamped with the cycle in which it is due. At each edge it first applies writes from the current `wdata`, then forms the expected read result. The outputs are compared a quarter period after every rising edge, when both the registered values and the asynchronous enables have settled.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int unsigned BURST_W = 2;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    // low address bits of a burst beat: linear adds, interleaved flips
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               ilv
    );
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/lw_burst_gen.sv
module lw_burst_gen
    import lw_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel,
    input  logic              adv,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] bw_n,
    input  logic              ilv,
    output logic              cmd_v,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [NBYTES-1:0] cmd_bwn
);

    typedef struct packed {
        logic               active;
        op_e                op;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
    } bst_t;

    bst_t st_d, st_q;
    logic [BURST_W-1:0] cnt_nx;

    always_comb begin
        st_d     = st_q;
        cmd_v    = 1'b0;
        cmd_op   = st_q.op;
        cmd_addr = st_q.base;
        cmd_bwn  = bw_n;
        cnt_nx   = st_q.cnt + 1'b1;
        if (sleep) begin
            st_d.active = 1'b0;
        end else if (!adv) begin
            if (sel) begin
                st_d.active = 1'b1;
                st_d.op     = we_n ? OP_RD : OP_WR;
                st_d.base   = addr;
                st_d.cnt    = '0;
                cmd_v       = 1'b1;
                cmd_op      = we_n ? OP_RD : OP_WR;
                cmd_addr    = addr;
            end else begin
                st_d.active = 1'b0;
            end
        end else if (st_q.active) begin
            st_d.cnt = cnt_nx;
            cmd_v    = 1'b1;
            cmd_addr = {st_q.base[ADDR_W-1:BURST_W],
                        burst_low(st_q.base[BURST_W-1:0], cnt_nx, ilv)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, op: OP_RD, base: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R1: deselect issues nothing
    p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !adv && !sel) |-> !cmd_v);

    // R10: sleep blocks every command
    p_sleep_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !cmd_v);

    // R12: stray advance issues nothing
    p_stray_adv_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !st_q.active) |-> !cmd_v);

    // R7: a burst beat stays inside its aligned group of four
    p_burst_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v && adv) |-> (cmd_addr[ADDR_W-1:BURST_W] == st_q.base[ADDR_W-1:BURST_W]));

endmodule

// File: rtl/lw_late_pipe.sv
module lw_late_pipe
    import lw_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned NBYTES = 2,
    parameter int unsigned BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pipe_mode,
    input  logic                     cmd_v,
    input  op_e                      cmd_op,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [NBYTES-1:0]        cmd_bwn,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic [NBYTES*BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [NBYTES-1:0]        wr_ben,
    output logic [NBYTES*BYTE_W-1:0] wr_data,
    output logic [NBYTES*BYTE_W-1:0] q_data,
    output logic                     q_live
);

    localparam int unsigned DATA_W = NBYTES * BYTE_W;

    typedef struct packed {
        logic              v;
        op_e               op;
        logic [ADDR_W-1:0] a;
        logic [NBYTES-1:0] bwn;
    } stg_t;

    typedef struct packed {
        stg_t              s1;
        stg_t              s2;
        logic [DATA_W-1:0] oq;
    } pst_t;

    pst_t st_d, st_q;
    stg_t ret;
    logic fwd_hit;
    logic [DATA_W-1:0] merged;

    // write retirement stage and same-edge forwarding lanes
    assign ret     = pipe_mode ? st_q.s2 : st_q.s1;
    assign fwd_hit = pipe_mode && st_q.s2.v && (st_q.s2.op == OP_WR) &&
                     (st_q.s2.a == st_q.s1.a);

    for (genvar b = 0; b < NBYTES; b++) begin : g_fwd
        assign merged[b*BYTE_W +: BYTE_W] = (fwd_hit && !st_q.s2.bwn[b]) ?
            wdata[b*BYTE_W +: BYTE_W] : rd_data[b*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d        = st_q;
        st_d.s1     = '{v: cmd_v, op: cmd_op, a: cmd_addr, bwn: cmd_bwn};
        st_d.s2     = st_q.s1;
        if (st_q.s1.v && st_q.s1.op == OP_RD) begin
            st_d.oq = merged;
        end
        rd_addr = st_q.s1.a;
        wr_en   = ret.v && (ret.op == OP_WR);
        wr_addr = ret.a;
        wr_ben  = ~ret.bwn;
        wr_data = wdata;
        if (pipe_mode) begin
            q_data = st_q.oq;
            q_live = st_q.s2.v && (st_q.s2.op == OP_RD);
        end else begin
            q_data = rd_data;
            q_live = st_q.s1.v && (st_q.s1.op == OP_RD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '{v: 1'b0, op: OP_RD, a: '0, bwn: '1},
                      s2: '{v: 1'b0, op: OP_RD, a: '0, bwn: '1},
                      oq: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R2: flow-through read result one stage after its command
    p_flow_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && q_live) |-> $past(cmd_v && cmd_op == OP_RD));

    // R3: registered read result two stages after its command
    p_pipe_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && q_live) |-> $past(cmd_v && cmd_op == OP_RD, 2));

    // R4: write retires on the edge that samples its late data
    p_flow_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && wr_en) |-> $past(cmd_v && cmd_op == OP_WR));

    p_pipe_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && wr_en) |-> $past(cmd_v && cmd_op == OP_WR, 2));

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned NBYTES = 2,
    parameter int unsigned BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_ben,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_q [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    lane_q[i] <= '0;
                end
            end else if (wr_en && wr_ben[b]) begin
                lane_q[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[b*BYTE_W +: BYTE_W] = lane_q[rd_addr];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned NBYTES = 2,
    parameter int unsigned BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pipe_mode,
    input  logic                     burst_ilv,
    input  logic                     cs0_n,
    input  logic                     cs1,
    input  logic                     cs2_n,
    input  logic                     adv,
    input  logic                     we_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES-1:0]        bw_n,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic                     oe_n,
    input  logic                     sleep,
    output logic [NBYTES*BYTE_W-1:0] dq_out,
    output logic                     dq_drv
);

    localparam int unsigned DATA_W = NBYTES * BYTE_W;

    logic              sel;
    logic              cmd_v;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [NBYTES-1:0] cmd_bwn;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [NBYTES-1:0] wr_ben;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] q_data;
    logic              q_live;

    assign sel = !cs0_n && cs1 && !cs2_n;

    lw_burst_gen #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .sel      (sel),
        .adv      (adv),
        .we_n     (we_n),
        .addr     (addr),
        .bw_n     (bw_n),
        .ilv      (burst_ilv),
        .cmd_v    (cmd_v),
        .cmd_op   (cmd_op),
        .cmd_addr (cmd_addr),
        .cmd_bwn  (cmd_bwn)
    );

    lw_late_pipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .cmd_v     (cmd_v),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_bwn   (cmd_bwn),
        .wdata     (wdata),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_ben    (wr_ben),
        .wr_data   (wr_data),
        .q_data    (q_data),
        .q_live    (q_live)
    );

    lw_sram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_ben  (wr_ben),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // asynchronous driver control overrides the synchronous read slot
    assign dq_drv = q_live && !oe_n && !sleep;
    assign dq_out = dq_drv ? q_data : '0;

    // R11: nothing reaches the bus in the first cycle after reset
    p_quiet_after_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dq_drv);

endmodule

// File: tb/lw_sram_bench.sv
module lw_sram_bench;

    localparam int CLK_P = 10;
    localparam int AW = 6;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pipe_mode = 1'b0;
    logic burst_ilv = 1'b0;
    logic cs0_n = 1'b1;
    logic cs1 = 1'b0;
    logic cs2_n = 1'b1;
    logic adv = 1'b0;
    logic we_n = 1'b1;
    logic oe_n = 1'b0;
    logic sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] bw_n = '1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] dq_out;
    logic dq_drv;

    always #(CLK_P/2) clk = ~clk;

    lw_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) u_lw_sram (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .adv(adv), .we_n(we_n),
        .addr(addr), .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
        .dq_out(dq_out), .dq_drv(dq_drv)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R11";
    bit done = 1'b0;

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct {
        int            due;
        bit            wr;
        int            a;
        logic [NB-1:0] bwn;
    } op_t;

    op_t pend[$];
    op_t keep[$];
    logic [DW-1:0] m_mem [0:(1<<AW)-1];
    bit m_act = 0;
    bit m_wr = 0;
    int m_base = 0;
    int m_cnt = 0;
    bit exp_rd = 0;
    logic [DW-1:0] exp_data = '0;
    bit new_v;
    int new_a;
    int lo;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
            pend.delete();
            m_act = 0;
            exp_rd = 0;
        end else begin
            cyc++;
            exp_rd = 0;
            foreach (pend[i]) begin
                if (pend[i].wr && pend[i].due == cyc) begin
                    for (int b = 0; b < NB; b++) begin
                        if (!pend[i].bwn[b]) m_mem[pend[i].a][b*BW +: BW] = wdata[b*BW +: BW];
                    end
                end
            end
            new_v = 0;
            new_a = 0;
            if (sleep) begin
                m_act = 0;
            end else if (!adv) begin
                if (!cs0_n && cs1 && !cs2_n) begin
                    m_act = 1; m_wr = !we_n; m_base = int'(addr); m_cnt = 0;
                    new_v = 1; new_a = int'(addr);
                end else begin
                    m_act = 0;
                end
            end else if (m_act) begin
                m_cnt = (m_cnt + 1) % 4;
                lo = burst_ilv ? ((m_base % 4) ^ m_cnt) : ((m_base % 4 + m_cnt) % 4);
                new_v = 1;
                new_a = (m_base / 4) * 4 + lo;
            end
            if (new_v) begin
                pend.push_back('{m_wr ? cyc + (pipe_mode ? 2 : 1) : cyc + (pipe_mode ? 1 : 0),
                                 m_wr, new_a, bw_n});
            end
            foreach (pend[i]) begin
                if (!pend[i].wr && pend[i].due == cyc) begin
                    exp_rd = 1;
                    exp_data = m_mem[pend[i].a];
                end
            end
            keep.delete();
            foreach (pend[i]) if (pend[i].due > cyc) keep.push_back(pend[i]);
            pend = keep;
        end
    end

    // compare a quarter period after every rising edge
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (!done) begin
            if (!rst_n) begin
                chk("dq_drv in reset", {17'd0, dq_drv}, '0);   // R11
            end else begin
                chk("dq_drv", {17'd0, dq_drv}, {17'd0, exp_rd && !oe_n && !sleep});
                chk("dq_out", dq_out, (exp_rd && !oe_n && !sleep) ? exp_data : '0);
            end
        end
    end

    // write data changes every cycle so every late sample is distinct
    always @(negedge clk) wdata <= DW'(cyc * 32'h0001_3579 ^ 32'h0002_a5c3);

    // ---------------- stimulus ----------------
    task automatic op_cs(input bit wr, input int a, input logic [NB-1:0] bwn, input logic [2:0] c);
        @(negedge clk);
        adv = 0; cs0_n = !c[0]; cs1 = c[1]; cs2_n = !c[2];
        we_n = !wr; addr = AW'(a); bw_n = bwn;
    endtask

    task automatic op(input bit wr, input int a, input logic [NB-1:0] bwn);
        op_cs(wr, a, bwn, 3'b111);
    endtask

    task automatic cont(input int n);
        repeat (n) begin @(negedge clk); adv = 1; end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); adv = 0; cs0_n = 1; end
    endtask

    task automatic restart(input bit pm, input bit il);
        @(negedge clk);
        rst_n = 0; pipe_mode = pm; burst_ilv = il; adv = 0; cs0_n = 1;
        idle(2);
        rst_n = 1;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic run_mode();
        cur_req = "R2";
        if (pipe_mode) cur_req = "R3";
        op(1, 3, 2'b00); op(0, 3, 2'b00); idle(3);
        cur_req = "R4";
        op(1, 4, 2'b00); idle(1); op(0, 4, 2'b00); idle(3);
        cur_req = "R6";
        for (int i = 0; i < 12; i++) op(i % 2 == 0, 10 + (i % 3), 2'b00);
        op(1, 7, 2'b00); op(0, 7, 2'b00);
        op(1, 7, 2'b00); op(1, 7, 2'b10); op(0, 7, 2'b00); op(0, 7, 2'b00);
        idle(3);
        cur_req = "R5";
        op(1, 20, 2'b00); op(1, 20, 2'b10); op(1, 20, 2'b01); idle(2);
        op(0, 20, 2'b00); op(1, 21, 2'b11); op(0, 21, 2'b00); idle(3);
        cur_req = "R1";
        op_cs(1, 30, 2'b00, 3'b110); op_cs(1, 30, 2'b00, 3'b101);
        op_cs(1, 30, 2'b00, 3'b011); op_cs(0, 30, 2'b00, 3'b011);
        idle(2); op(0, 30, 2'b00); idle(3);
        cur_req = "R7";
        burst_ilv = 0;
        op(1, 33, 2'b00); cont(3); op(0, 33, 2'b00); cont(5); idle(3);
        op(0, 34, 2'b00); cont(3); idle(3);
        cur_req = "R8";
        burst_ilv = 1;
        op(1, 46, 2'b00); cont(3); op(0, 46, 2'b00); cont(3); idle(1);
        op(0, 45, 2'b00); cont(3); idle(3);
        cur_req = "R12";
        cont(3); idle(1); op(0, 46, 2'b00); idle(3);
        cur_req = "R9";
        op(0, 33, 2'b00); oe_n = 1; op(0, 34, 2'b00); op(1, 35, 2'b00);
        op(0, 35, 2'b00); oe_n = 0; op(0, 33, 2'b00); idle(3);
        cur_req = "R10";
        op(1, 50, 2'b00); op(0, 50, 2'b00); sleep = 1;
        op(1, 50, 2'b00); op(0, 50, 2'b00); cont(2); op(1, 51, 2'b00);
        @(negedge clk); sleep = 0; adv = 1;
        idle(1); op(0, 50, 2'b00); op(0, 51, 2'b00); idle(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R11";
        idle(2); op(0, 5, 2'b00); op(0, 63, 2'b00); idle(3);
        run_mode();
        restart(1, 0);
        cur_req = "R11";
        op(0, 5, 2'b00); idle(3);
        run_mode();
        idle(4);
        done = 1;
        report();
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        done = 1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule